// File: doc/BRIEF.md
# Pipeline Hazard Stall Controller

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). The register file is read in decode and written only in write-back. A decoding instruction can therefore name a register whose new value has not yet been written back. The controller compares the two source register indices of the decoding instruction with the destination indices held in the execute, memory and write-back pipeline registers. From these comparisons it decides whether the decoding instruction has to wait.

While a wait is needed, the controller does three things:
- It holds the program counter.
- It holds the fetch/decode pipeline register.
- It turns the instruction passed into execute into a harmless bubble, by clearing its memory-write and register-write enables.

A parameter chosen at elaboration selects one of two policies:
- **Stall-only:** every pending dependence stalls.
- **Forwarding-assisted:** the surrounding datapath bypasses ALU results, so only a load in execute followed by a dependent use stalls.

The logic is purely combinational. Register indices are three bits wide, for an eight-register machine.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: In stall-only mode, `stall` is 1 when `id_src_a` is nonzero and equals the destination of the execute, memory or write-back stage whose register-write enable is 1.
- R2: In stall-only mode, the same rule as R1 applies to `id_src_b`.
- R3: A source index of 0 never causes a stall, in either mode, whatever the later stages hold.
- R4: A later stage whose register-write enable is 0 never causes a stall, even when its destination index matches a source.
- R5: `pc_en` and `ifid_en` are both 0 when `stall` is 1, and both 1 when `stall` is 0.
- R6: When `stall` is 1, `idex_regwr` and `idex_memwr` are 0. Otherwise they equal `id_regwr` and `id_memwr`.
- R7: In forwarding mode, `stall` is 1 only when the execute stage holds a load. A load means `ex_memrd`=1 and `ex_regwr`=1, with a destination equal to a nonzero source. Matches in the memory or write-back stage, or with a non-load in execute, do not stall.
- R8: `stall` falls in the same cycle in which the producing instruction leaves the last compared stage. There is no extra wait cycle, so the held instruction advances on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | 3 | First source register index of the decoding instruction |
| id_src_b | input | 3 | Second source register index of the decoding instruction |
| id_regwr | input | 1 | Register-write enable decoded for the decoding instruction |
| id_memwr | input | 1 | Memory-write enable decoded for the decoding instruction |
| ex_dst | input | 3 | Destination index held in the execute-stage register |
| ex_regwr | input | 1 | Register-write enable of the execute-stage instruction |
| ex_memrd | input | 1 | The execute-stage instruction is a load |
| mem_dst | input | 3 | Destination index held in the memory-stage register |
| mem_regwr | input | 1 | Register-write enable of the memory-stage instruction |
| wb_dst | input | 3 | Destination index held in the write-back-stage register |
| wb_regwr | input | 1 | Register-write enable of the write-back-stage instruction |
| stall | output | 1 | The decoding instruction must wait this cycle |
| pc_en | output | 1 | Program counter update enable |
| ifid_en | output | 1 | Fetch/decode pipeline register load enable |
| idex_regwr | output | 1 | Register-write enable passed into the execute stage |
| idex_memwr | output | 1 | Memory-write enable passed into the execute stage |

## Verification
The hardest situation to reach is a dependence that moves through the later stages across consecutive cycles. Stall-only mode must hold for exactly three cycles and then release. Forwarding mode must hold only while the load sits in execute, and then release while the load is still in memory and write-back. The stimulus replays these walks cycle by cycle: the producer's destination is moved from execute to memory to write-back and then retired. Both mode instances see the same inputs, so the number of stall cycles in each policy is checked against the same sequence. Register 0 and disabled writers are driven with matching indices, to show that they do not stall.

// File: rtl/hsc_pkg.sv
// Shared definitions for the hazard stall controller.
// Assumes three later pipeline stages and two source operands per instruction.
package hsc_pkg;

    // Stall policy chosen at elaboration
    typedef enum logic {
        MODE_STALL_ONLY = 1'b0,
        MODE_FORWARD    = 1'b1
    } stall_mode_e;

    // Number of source operands compared per decoding instruction
    localparam int NSRC = 2;
    // Number of later stages compared: execute, memory, write-back
    localparam int NSTG = 3;
    // Stage positions inside the comparison grid
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int STG_WB  = 2;

endpackage

// File: rtl/hsc_src_match.sv
// One source-versus-destination comparator.
// Reports a hit when the stage writes a register, the source is not
// register 0, and the indices are equal. Purely combinational.
module hsc_src_match #(
    parameter int REG_W = 3
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wen,
    output logic             hit
);

    // Compare one source against one later-stage destination
    always_comb begin
        hit = wen && (src != '0) && (src == dst);
    end

endmodule

// File: rtl/hsc_stall_policy.sv
// Turns the grid of comparator hits into one stall decision.
// Stall-only mode stalls on any hit. Forwarding mode stalls only on an
// execute-stage hit by a load. Hit index = source * NSTG + stage.
module hsc_stall_policy
    import hsc_pkg::*;
#(
    parameter stall_mode_e MODE = MODE_STALL_ONLY
) (
    input  logic [NSRC*NSTG-1:0] hits,
    input  logic                 ex_is_load,
    output logic                 stall
);

    generate
        if (MODE == MODE_FORWARD) begin : g_fwd
            logic ex_any;
            // Results of ALU stages are bypassed; mark remaining hits as intentionally unused
            wire unused_far = ^hits;

            // Collect execute-stage hits across all sources
            always_comb begin
                ex_any = 1'b0;
                for (int s = 0; s < NSRC; s++) begin
                    ex_any = ex_any | hits[s*NSTG + STG_EX];
                end
            end

            // Only a load in execute cannot be forwarded in time
            always_comb begin
                stall = ex_any && ex_is_load;
            end
        end else begin : g_stall_only
            // Load flag is irrelevant when every dependence waits
            wire unused_load = ex_is_load;

            // Any pending writer of a source forces a wait
            always_comb begin
                stall = |hits;
            end
        end
    endgenerate

endmodule

// File: rtl/hsc_bubble_gen.sv
// Applies a stall decision to the pipeline controls.
// Freezes the program counter and fetch/decode register, and clears the
// write enables handed to execute so that a bubble proceeds.
module hsc_bubble_gen (
    input  logic stall,
    input  logic id_regwr,
    input  logic id_memwr,
    output logic pc_en,
    output logic ifid_en,
    output logic idex_regwr,
    output logic idex_memwr
);

    // Hold the front end while stalled
    always_comb begin
        pc_en   = !stall;
        ifid_en = !stall;
    end

    // Neutralize the instruction entering execute while stalled
    always_comb begin
        idex_regwr = id_regwr && !stall;
        idex_memwr = id_memwr && !stall;
    end

endmodule

// File: rtl/hazard_stall_ctrl.sv
// Decode-stage hazard stall controller for a five-stage in-order pipeline.
// Builds a grid of source/destination comparators, applies the stall policy
// chosen by MODE, and drives the front-end freeze and bubble enables.
// Assumes no register-file bypass: a write-back match counts as pending.
module hazard_stall_ctrl
    import hsc_pkg::*;
#(
    parameter int          REG_W = 3,
    parameter stall_mode_e MODE  = MODE_STALL_ONLY
) (
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_regwr,
    input  logic             id_memwr,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             ex_regwr,
    input  logic             ex_memrd,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             mem_regwr,
    input  logic [REG_W-1:0] wb_dst,
    input  logic             wb_regwr,
    output logic             stall,
    output logic             pc_en,
    output logic             ifid_en,
    output logic             idex_regwr,
    output logic             idex_memwr
);

    localparam int NHIT = NSRC * NSTG;

    logic [REG_W-1:0] srcs [NSRC];
    logic [REG_W-1:0] dsts [NSTG];
    logic             wens [NSTG];
    logic [NHIT-1:0]  hits;
    logic             ex_is_load;

    // Gather operands and stage fields into indexable arrays
    always_comb begin
        srcs[0]       = id_src_a;
        srcs[1]       = id_src_b;
        dsts[STG_EX]  = ex_dst;
        dsts[STG_MEM] = mem_dst;
        dsts[STG_WB]  = wb_dst;
        wens[STG_EX]  = ex_regwr;
        wens[STG_MEM] = mem_regwr;
        wens[STG_WB]  = wb_regwr;
        ex_is_load    = ex_memrd;
    end

    genvar s, k;
    generate
        for (s = 0; s < NSRC; s++) begin : g_src
            for (k = 0; k < NSTG; k++) begin : g_stg
                hsc_src_match #(.REG_W(REG_W)) u_match (
                    .src (srcs[s]),
                    .dst (dsts[k]),
                    .wen (wens[k]),
                    .hit (hits[s*NSTG + k])
                );
            end
        end
    endgenerate

    hsc_stall_policy #(.MODE(MODE)) u_policy (
        .hits       (hits),
        .ex_is_load (ex_is_load),
        .stall      (stall)
    );

    hsc_bubble_gen u_bubble (
        .stall      (stall),
        .id_regwr   (id_regwr),
        .id_memwr   (id_memwr),
        .pc_en      (pc_en),
        .ifid_en    (ifid_en),
        .idex_regwr (idex_regwr),
        .idex_memwr (idex_memwr)
    );

endmodule

// File: rtl/hsc_checker.sv
// Assertion checker for hazard_stall_ctrl, attached by bind.
// The controller has no clock, so all checks are immediate assertions
// evaluated whenever the inputs or outputs change.
module hsc_checker
    import hsc_pkg::*;
#(
    parameter int          REG_W = 3,
    parameter stall_mode_e MODE  = MODE_STALL_ONLY
) (
    input logic [REG_W-1:0] id_src_a,
    input logic [REG_W-1:0] id_src_b,
    input logic             id_regwr,
    input logic             id_memwr,
    input logic             ex_regwr,
    input logic             ex_memrd,
    input logic             mem_regwr,
    input logic             wb_regwr,
    input logic             stall,
    input logic             pc_en,
    input logic             ifid_en,
    input logic             idex_regwr,
    input logic             idex_memwr
);

    // Check the relations between inputs and controls
    always_comb begin
        a_r3_zero_sources_never_stall:
            assert (!((id_src_a == '0) && (id_src_b == '0) && stall))
            else $error("zero sources produced a stall");
        a_r4_no_writers_no_stall:
            assert (!(!ex_regwr && !mem_regwr && !wb_regwr && stall))
            else $error("stall without any writing stage");
        a_r5_front_end_frozen:
            assert (stall ? (!pc_en && !ifid_en) : (pc_en && ifid_en))
            else $error("front-end enables disagree with stall");
        a_r6_bubble_enables:
            assert (stall ? (!idex_regwr && !idex_memwr)
                          : ((idex_regwr == id_regwr) && (idex_memwr == id_memwr)))
            else $error("execute enables wrong for stall state");
        a_r7_forward_stalls_on_load_only:
            assert (!((MODE == MODE_FORWARD) && stall && !(ex_memrd && ex_regwr)))
            else $error("forwarding mode stalled without a load in execute");
    end

endmodule

bind hazard_stall_ctrl hsc_checker #(.REG_W(REG_W), .MODE(MODE)) u_hsc_checker (
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .id_regwr   (id_regwr),
    .id_memwr   (id_memwr),
    .ex_regwr   (ex_regwr),
    .ex_memrd   (ex_memrd),
    .mem_regwr  (mem_regwr),
    .wb_regwr   (wb_regwr),
    .stall      (stall),
    .pc_en      (pc_en),
    .ifid_en    (ifid_en),
    .idex_regwr (idex_regwr),
    .idex_memwr (idex_memwr)
);

// File: tb/tb_hazard_stall_ctrl.sv
`timescale 1ns/100ps
// Scoreboard bench: a driver task applies a vector on the rising edge and
// queues its expected stall for both policies; a monitor pops the entry on
// the falling edge and compares every output of both instances.
module tb_hazard_stall_ctrl;
    import hsc_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [2:0] id_src_a = '0, id_src_b = '0, ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic id_regwr = 0, id_memwr = 0, ex_regwr = 0, ex_memrd = 0, mem_regwr = 0, wb_regwr = 0;

    logic so_stall, so_pc, so_ifid, so_rw, so_mw;
    logic fw_stall, fw_pc, fw_ifid, fw_rw, fw_mw;

    hazard_stall_ctrl #(.REG_W(3), .MODE(MODE_STALL_ONLY)) dut (
        .id_src_a(id_src_a), .id_src_b(id_src_b), .id_regwr(id_regwr), .id_memwr(id_memwr),
        .ex_dst(ex_dst), .ex_regwr(ex_regwr), .ex_memrd(ex_memrd),
        .mem_dst(mem_dst), .mem_regwr(mem_regwr), .wb_dst(wb_dst), .wb_regwr(wb_regwr),
        .stall(so_stall), .pc_en(so_pc), .ifid_en(so_ifid),
        .idex_regwr(so_rw), .idex_memwr(so_mw)
    );

    hazard_stall_ctrl #(.REG_W(3), .MODE(MODE_FORWARD)) dut_fw (
        .id_src_a(id_src_a), .id_src_b(id_src_b), .id_regwr(id_regwr), .id_memwr(id_memwr),
        .ex_dst(ex_dst), .ex_regwr(ex_regwr), .ex_memrd(ex_memrd),
        .mem_dst(mem_dst), .mem_regwr(mem_regwr), .wb_dst(wb_dst), .wb_regwr(wb_regwr),
        .stall(fw_stall), .pc_en(fw_pc), .ifid_en(fw_ifid),
        .idex_regwr(fw_rw), .idex_memwr(fw_mw)
    );

    typedef struct {
        string req;
        logic  exp_so;
        logic  exp_fw;
        logic  rw;
        logic  mw;
    } exp_t;

    exp_t sb_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    logic done = 0;

    // Drive one vector at a rising edge and queue what each policy must produce
    task automatic vec(input logic [2:0] sa, input logic [2:0] sb, input logic rw, input logic mw,
                       input logic [2:0] ed, input logic erw, input logic emr,
                       input logic [2:0] md, input logic mrw,
                       input logic [2:0] wd, input logic wrw,
                       input logic e_so, input logic e_fw, input string req);
        exp_t e;
        @(posedge clk);
        #1;
        id_src_a = sa; id_src_b = sb; id_regwr = rw; id_memwr = mw;
        ex_dst = ed; ex_regwr = erw; ex_memrd = emr;
        mem_dst = md; mem_regwr = mrw; wb_dst = wd; wb_regwr = wrw;
        e.req = req; e.exp_so = e_so; e.exp_fw = e_fw; e.rw = rw; e.mw = mw;
        sb_q.push_back(e);
    endtask

    // Compare one instance against its expected stall and derived controls
    task automatic cmp(input string who, input string req, input logic exp_st, input logic rw,
                       input logic mw, input logic st, input logic pc, input logic ifid,
                       input logic orw, input logic omw);
        logic [4:0] act, exp;
        act = {st, pc, ifid, orw, omw};
        exp = {exp_st, !exp_st, !exp_st, rw && !exp_st, mw && !exp_st};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s (R5 R6 derived): {stall,pc,ifid,rw,mw} actual=%b expected=%b",
                     req, who, act, exp);
        end
    endtask

    // Monitor: pop expectations away from the driving edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp("stall-only", e.req, e.exp_so, e.rw, e.mw, so_stall, so_pc, so_ifid, so_rw, so_mw);
            cmp("forward",    e.req, e.exp_fw, e.rw, e.mw, fw_stall, fw_pc, fw_ifid, fw_rw, fw_mw);
        end
    end

    initial begin
        // R3 initial idle state: nothing pending
        vec(0,0,0,0, 0,0,0, 0,0, 0,0, 0,0, "R3 idle");
        // R1 source A against each stage, non-load writer
        vec(3,1,1,0, 3,1,0, 0,0, 0,0, 1,0, "R1 srcA vs EX");
        vec(3,1,1,0, 0,0,0, 3,1, 0,0, 1,0, "R1 srcA vs MEM");
        vec(3,1,1,0, 0,0,0, 0,0, 3,1, 1,0, "R1 srcA vs WB");
        // R2 source B
        vec(1,5,1,1, 5,1,0, 0,0, 0,0, 1,0, "R2 srcB vs EX");
        vec(1,5,0,1, 0,0,0, 0,0, 5,1, 1,0, "R2 srcB vs WB");
        // R3 register 0 sources against a load writing r0
        vec(0,0,1,0, 0,1,1, 0,1, 0,1, 0,0, "R3 zero sources");
        // R4 matching indices but write enables clear
        vec(4,4,1,0, 4,0,0, 4,0, 4,0, 0,0, "R4 disabled writers");
        // R7 load-use on each source; R6 bubble clears memwr
        vec(2,1,1,1, 2,1,1, 0,0, 0,0, 1,1, "R7 load-use srcA");
        vec(1,6,1,0, 6,1,1, 0,0, 0,0, 1,1, "R7 load-use srcB");
        vec(2,3,1,0, 1,1,1, 0,0, 0,0, 0,0, "R7 load other reg");
        vec(2,3,1,0, 2,0,1, 0,0, 0,0, 0,0, "R7 load flag without regwr");
        // R6 pass-through of enables with no hazard
        vec(6,7,1,1, 1,1,0, 2,1, 3,1, 0,0, "R6 pass-through");
        // R8 ALU producer walks EX, MEM, WB then retires
        vec(1,3,1,0, 3,1,0, 0,0, 0,0, 1,0, "R8 alu walk EX");
        vec(1,3,1,0, 0,0,0, 3,1, 0,0, 1,0, "R8 alu walk MEM");
        vec(1,3,1,0, 0,0,0, 0,0, 3,1, 1,0, "R8 alu walk WB");
        vec(1,3,1,0, 0,0,0, 0,0, 0,0, 0,0, "R8 alu released");
        // R8 load producer: forwarding releases once the load leaves EX
        vec(4,0,1,1, 4,1,1, 0,0, 0,0, 1,1, "R8 load walk EX");
        vec(4,0,1,1, 0,0,0, 4,1, 0,0, 1,0, "R8 load walk MEM");
        vec(4,0,1,1, 0,0,0, 0,0, 4,1, 1,0, "R8 load walk WB");
        vec(4,0,1,1, 0,0,0, 0,0, 0,0, 0,0, "R8 load released");
        // Let the last entries drain
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule